// File: doc/BRIEF.md
# Dual-Channel Regulator Start-Up Sequencer

This block is the digital control for two regulator channels that share one reference. Two enable inputs request the channels. When neither is requested the block sits in a low-power idle state and asserts a global power-down signal. When either is requested, it first waits for the supply monitor to report an adequate input voltage. It then powers up the shared circuitry one step at a time, and each step must report completion before the next begins. Only after the last step does it release the per-channel ramp enables.

Channel 1 has start-up priority. Channel 2 is held back while channel 1 is ramping toward regulation, unless channel 2 had already begun ramping when channel 1 was requested. An over-temperature event turns off only the channels that report a heavy load. Those channels return with a fresh ramp once the cool-down flag is seen. A supply drop stops everything within one clock, and the full sequence repeats automatically once the supply recovers. Each preparation step is guarded by a timeout. If a step times out, the block returns to idle and raises a fault flag that stays set until reset.

Top module: `dual_rail_seq`

## Requirements
- R1: With both channel enables low, `pwr_down_o` is 1 and `step_en_o` and `ramp_en_o` are all zero. This holds after reset and within four clocks of both enables going low.
- R2: Each enable passes through a two-stage synchronizer. After an enable rises from idle, `pwr_down_o` is still 1 after two clock edges and is 0 after the third.
- R3: While `supply_ok_i` is 0, no preparation step is enabled and no channel ramps, even with enables asserted.
- R4: `step_en_o` is a thermometer code in the fixed order bit 0 trim latch, bit 1 bandgap, bit 2 reference, bit 3 current generator, bit 4 bypass fast-charge. Bit k+1 rises only after `step_done_i[k]` is seen while bit k is the highest bit set. No ramp enable rises before `step_done_i[4]`.
- R5: If channel 1 is requested at the same time as or before channel 2, `ramp_en_o[0]` rises first. `ramp_en_o[1]` stays 0 until `ch1_in_reg_i` is 1.
- R6: If channel 2 is requested first and channel 1 arrives before channel 2 has started ramping, channel 1 ramps first and channel 2 waits for `ch1_in_reg_i`.
- R7: If channel 1 is requested while channel 2 is already ramping, `ramp_en_o[0]` rises without waiting, and channel 2 keeps ramping.
- R8: When `supply_ok_i` falls, all ramp and step enables are 0 one clock later. When it returns, the sequence restarts from the trim step.
- R9: On `over_temp_i`, only ramping channels whose `heavy_load_i` bit is 1 are turned off. If both bits are 1, both channels are turned off.
- R10: A channel turned off by over-temperature stays off until `cool_i` is 1, then its ramp enable rises again.
- R11: If a step's done input is not seen within STEP_TIMEOUT clocks, the block returns to idle (`pwr_down_o` is 1 for at least one clock) and `fault_o` becomes 1. `fault_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 2 | Asynchronous channel requests, bit 0 = channel 1 |
| supply_ok_i | input | 1 | Supply monitor, 1 = above threshold (hysteresis applied outside) |
| step_done_i | input | 5 | Completion flag of each preparation step |
| ch1_in_reg_i | input | 1 | Channel 1 output has reached its target |
| over_temp_i | input | 1 | Die over-temperature flag |
| cool_i | input | 1 | Die has cooled below the restart threshold |
| heavy_load_i | input | 2 | Per-channel load above the heavy threshold |
| step_en_o | output | 5 | Preparation step enables, thermometer code |
| ramp_en_o | output | 2 | Per-channel ramp enable, bit 0 = channel 1 |
| pwr_down_o | output | 1 | Global power-down, 1 in idle |
| fault_o | output | 1 | Sticky step-timeout fault |

## Verification
The bench builds the block with STEP_TIMEOUT set to 16 and keeps the default five steps and two synchronizer stages. The short timeout makes the expiry path and the sticky fault reachable within a few dozen clocks. It also leaves enough margin for the bench to watch each step hold before its done pulse. With the default stage count, the synchronizer latency is an exact count of three clocks, which the bench checks on the edge where it changes.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_UVWAIT = 2'd1,
        ST_STEP   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rail_en_sync.sv
module rail_en_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/rail_step_timer.sv
module rail_step_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (run_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q >= CW'(LIMIT - 1));

endmodule

// File: rtl/rail_chan_arb.sv
module rail_chan_arb (
    input  logic [1:0] want_i,
    input  logic [1:0] ramp_q_i,
    input  logic [1:0] hot_off_q_i,
    input  logic       ch1_in_reg_i,
    input  logic       over_temp_i,
    input  logic       cool_i,
    input  logic [1:0] heavy_load_i,
    output logic [1:0] ramp_d_o,
    output logic [1:0] hot_off_d_o
);

    logic [1:0] live;

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            if (hot_off_q_i[k]) hot_off_d_o[k] = !cool_i;
            else                hot_off_d_o[k] = over_temp_i && heavy_load_i[k] && ramp_q_i[k];
        end
        live = want_i & ~hot_off_d_o;
        // channel 1 never waits; channel 2 waits only while channel 1 is still settling
        ramp_d_o[0] = live[0];
        ramp_d_o[1] = live[1] && (ramp_q_i[1] || !live[0] || ch1_in_reg_i);
    end

endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq #(
    parameter int N_STEPS      = 5,
    parameter int STEP_TIMEOUT = 1024,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         chan_en_i,
    input  logic               supply_ok_i,
    input  logic [N_STEPS-1:0] step_done_i,
    input  logic               ch1_in_reg_i,
    input  logic               over_temp_i,
    input  logic               cool_i,
    input  logic [1:0]         heavy_load_i,
    output logic [N_STEPS-1:0] step_en_o,
    output logic [1:0]         ramp_en_o,
    output logic               pwr_down_o,
    output logic               fault_o
);
    import rail_seq_pkg::*;

    localparam int IDX_W = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [N_STEPS-1:0] step_en;
        logic [1:0]         ramp;
        logic [1:0]         hot_off;
        logic               fault;
    } seq_regs_t;

    seq_regs_t  cur_q;
    seq_regs_t  nxt_d;
    logic [1:0] en_sync;
    logic       any_en;
    logic       done_sel;
    logic       tmr_clr;
    logic       tmr_run;
    logic       tmr_exp;
    logic [1:0] arb_ramp;
    logic [1:0] arb_hot_off;

    rail_en_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (chan_en_i),
        .sync_o  (en_sync)
    );

    rail_step_timer #(.LIMIT(STEP_TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    rail_chan_arb u_arb (
        .want_i       (en_sync),
        .ramp_q_i     (cur_q.ramp),
        .hot_off_q_i  (cur_q.hot_off),
        .ch1_in_reg_i (ch1_in_reg_i),
        .over_temp_i  (over_temp_i),
        .cool_i       (cool_i),
        .heavy_load_i (heavy_load_i),
        .ramp_d_o     (arb_ramp),
        .hot_off_d_o  (arb_hot_off)
    );

    assign any_en = |en_sync;

    always_comb begin
        done_sel = 1'b0;
        for (int k = 0; k < N_STEPS; k++) begin
            if (cur_q.idx == IDX_W'(k)) done_sel = step_done_i[k];
        end
    end

    always_comb begin
        nxt_d   = cur_q;
        tmr_clr = 1'b1;
        tmr_run = 1'b0;

        unique case (cur_q.st)
            ST_OFF: begin
                nxt_d.step_en = '0;
                nxt_d.ramp    = '0;
                nxt_d.hot_off = '0;
                nxt_d.idx     = '0;
                if (any_en) nxt_d.st = ST_UVWAIT;
            end
            ST_UVWAIT: begin
                if (supply_ok_i) begin
                    nxt_d.st      = ST_STEP;
                    nxt_d.idx     = '0;
                    nxt_d.step_en = N_STEPS'(1);
                end
            end
            ST_STEP: begin
                tmr_clr = 1'b0;
                tmr_run = 1'b1;
                if (done_sel) begin
                    tmr_clr = 1'b1;
                    if (cur_q.idx == IDX_W'(N_STEPS - 1)) begin
                        nxt_d.st = ST_RUN;
                    end else begin
                        nxt_d.idx = cur_q.idx + 1'b1;
                        for (int k = 0; k < N_STEPS; k++) begin
                            nxt_d.step_en[k] = (k <= int'(cur_q.idx) + 1);
                        end
                    end
                end else if (tmr_exp) begin
                    nxt_d.st      = ST_OFF;
                    nxt_d.fault   = 1'b1;
                    nxt_d.step_en = '0;
                    nxt_d.idx     = '0;
                end
            end
            ST_RUN: begin
                nxt_d.ramp    = arb_ramp;
                nxt_d.hot_off = arb_hot_off;
            end
            default: nxt_d.st = ST_OFF;
        endcase

        // global overrides: request removal wins over supply loss
        if (cur_q.st != ST_OFF && !any_en) begin
            nxt_d.st      = ST_OFF;
            nxt_d.step_en = '0;
            nxt_d.ramp    = '0;
            nxt_d.hot_off = '0;
            nxt_d.idx     = '0;
            tmr_clr       = 1'b1;
            tmr_run       = 1'b0;
        end else if ((cur_q.st == ST_STEP || cur_q.st == ST_RUN) && !supply_ok_i) begin
            nxt_d.st      = ST_UVWAIT;
            nxt_d.step_en = '0;
            nxt_d.ramp    = '0;
            nxt_d.hot_off = '0;
            nxt_d.idx     = '0;
            tmr_clr       = 1'b1;
            tmr_run       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= ST_OFF;
            cur_q.idx     <= '0;
            cur_q.step_en <= '0;
            cur_q.ramp    <= '0;
            cur_q.hot_off <= '0;
            cur_q.fault   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign step_en_o  = cur_q.step_en;
    assign ramp_en_o  = cur_q.ramp;
    assign pwr_down_o = (cur_q.st == ST_OFF);
    assign fault_o    = cur_q.fault;

endmodule

// File: rtl/dual_rail_seq_chk.sv
module dual_rail_seq_chk #(
    parameter int N_STEPS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               supply_ok_i,
    input logic               ch1_in_reg_i,
    input logic [N_STEPS-1:0] step_en_o,
    input logic [1:0]         ramp_en_o,
    input logic               pwr_down_o,
    input logic               fault_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> (step_en_o == '0 && ramp_en_o == '0)); // R1

    AST_STEP_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((N_STEPS'(step_en_o + 1'b1)) & step_en_o) == '0); // R4

    AST_RAMP_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        (|ramp_en_o) |-> (&step_en_o)); // R4

    AST_CH2_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ramp_en_o[1]) && ramp_en_o[0]) |-> $past(ch1_in_reg_i)); // R5

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (ramp_en_o == '0 && step_en_o == '0)); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o); // R11

endmodule

bind dual_rail_seq dual_rail_seq_chk #(.N_STEPS(N_STEPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok_i),
    .ch1_in_reg_i (ch1_in_reg_i),
    .step_en_o    (step_en_o),
    .ramp_en_o    (ramp_en_o),
    .pwr_down_o   (pwr_down_o),
    .fault_o      (fault_o)
);

// File: tb/dual_rail_seq_tb.sv
module dual_rail_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chan_en = 2'b00;
    logic       supply_ok = 1'b0;
    logic [4:0] step_done = '0;
    logic       ch1_in_reg = 1'b0;
    logic       over_temp = 1'b0;
    logic       cool = 1'b0;
    logic [1:0] heavy = 2'b00;
    logic [4:0] step_en;
    logic [1:0] ramp_en;
    logic       pwr_down;
    logic       fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_rail_seq #(.N_STEPS(5), .STEP_TIMEOUT(16), .SYNC_STAGES(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_en_i    (chan_en),
        .supply_ok_i  (supply_ok),
        .step_done_i  (step_done),
        .ch1_in_reg_i (ch1_in_reg),
        .over_temp_i  (over_temp),
        .cool_i       (cool),
        .heavy_load_i (heavy),
        .step_en_o    (step_en),
        .ramp_en_o    (ramp_en),
        .pwr_down_o   (pwr_down),
        .fault_o      (fault)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; chan_en = 2'b00; supply_ok = 1'b0; step_done = '0;
        ch1_in_reg = 1'b0; over_temp = 1'b0; cool = 1'b0; heavy = 2'b00;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_step(input int k);
        for (int i = 0; i < 10; i++) begin
            if (step_en == 5'((1 << (k + 1)) - 1)) break;
            tick(1);
        end
    endtask

    // R4: walk steps from first..4, checking each holds until its done pulse
    task automatic run_steps(input int first);
        for (int k = first; k < 5; k++) begin
            wait_step(k);
            chk("R4 step thermometer", int'(step_en), (1 << (k + 1)) - 1);
            tick(3);
            chk("R4 step holds without done", int'(step_en), (1 << (k + 1)) - 1);
            chk("R4 no ramp before last done", int'(ramp_en), 0);
            step_done[k] = 1'b1;
            tick(1);
            step_done[k] = 1'b0;
        end
    endtask

    task automatic t_reset_and_sync();
        do_reset();
        chk("R1 reset pwr_down", int'(pwr_down), 1);
        chk("R1 reset step_en", int'(step_en), 0);
        chk("R1 reset ramp", int'(ramp_en), 0);
        chan_en = 2'b01;
        tick(2);
        chk("R2 still idle after two edges", int'(pwr_down), 1);
        tick(1);
        chk("R2 leaves idle on third edge", int'(pwr_down), 0);
        tick(10);
        chk("R3 no step while supply low", int'(step_en), 0);
        chk("R3 no ramp while supply low", int'(ramp_en), 0);
    endtask

    task automatic t_ch1_first();
        do_reset();
        supply_ok = 1'b1;
        chan_en = 2'b11;
        run_steps(0);
        tick(2);
        chk("R5 ch1 ramps first", int'(ramp_en), 1);
        tick(5);
        chk("R5 ch2 held until ch1 in regulation", int'(ramp_en), 1);
        ch1_in_reg = 1'b1;
        tick(2);
        chk("R5 ch2 released", int'(ramp_en), 3);
    endtask

    task automatic t_ch2_then_ch1_early();
        do_reset();
        supply_ok = 1'b1;
        chan_en = 2'b10;
        run_steps_partial();
        chan_en = 2'b11;
        run_steps(2);
        tick(2);
        chk("R6 late ch1 still ramps first", int'(ramp_en), 1);
        ch1_in_reg = 1'b1;
        tick(2);
        chk("R6 ch2 follows ch1 regulation", int'(ramp_en), 3);
    endtask

    task automatic run_steps_partial();
        for (int k = 0; k < 2; k++) begin
            wait_step(k);
            step_done[k] = 1'b1;
            tick(1);
            step_done[k] = 1'b0;
        end
    endtask

    task automatic t_ch1_after_ch2_ramp_and_uv();
        do_reset();
        supply_ok = 1'b1;
        chan_en = 2'b10;
        run_steps(0);
        tick(3);
        chk("R7 ch2 alone ramps", int'(ramp_en), 2);
        chan_en = 2'b11;
        tick(4);
        chk("R7 ch1 joins without waiting", int'(ramp_en), 3);
        supply_ok = 1'b0;
        tick(1);
        chk("R8 ramps off after supply drop", int'(ramp_en), 0);
        chk("R8 steps off after supply drop", int'(step_en), 0);
        tick(3);
        supply_ok = 1'b1;
        tick(2);
        chk("R8 restart from trim step", int'(step_en), 1);
        run_steps(0);
        tick(2);
        chk("R8 restart uses ch1 priority", int'(ramp_en), 1);
        ch1_in_reg = 1'b1;
        tick(2);
        chk("R8 both back after restart", int'(ramp_en), 3);
    endtask

    task automatic t_overheat();
        heavy = 2'b10;
        over_temp = 1'b1;
        tick(1);
        over_temp = 1'b0;
        tick(1);
        chk("R9 only heavy ch2 off", int'(ramp_en), 1);
        tick(5);
        chk("R10 ch2 stays off before cool", int'(ramp_en), 1);
        cool = 1'b1;
        tick(1);
        cool = 1'b0;
        tick(1);
        chk("R10 ch2 restarts after cool", int'(ramp_en), 3);
        heavy = 2'b11;
        over_temp = 1'b1;
        tick(1);
        over_temp = 1'b0;
        tick(1);
        chk("R9 both heavy both off", int'(ramp_en), 0);
        cool = 1'b1;
        tick(1);
        cool = 1'b0;
        tick(1);
        chk("R10 both restart after cool", int'(ramp_en), 3);
        chan_en = 2'b00;
        tick(4);
        chk("R1 idle after enables drop", int'(pwr_down), 1);
        chk("R1 ramp cleared on idle", int'(ramp_en), 0);
        chk("R1 steps cleared on idle", int'(step_en), 0);
    endtask

    task automatic t_timeout();
        bit seen = 0;
        do_reset();
        supply_ok = 1'b1;
        chan_en = 2'b01;
        wait_step(0);
        for (int i = 0; i < 40; i++) begin
            tick(1);
            if (fault) begin
                seen = 1;
                chk("R11 idle on timeout", int'(pwr_down), 1);
                break;
            end
        end
        chk("R11 fault raised", int'(seen), 1);
        chan_en = 2'b00;
        tick(6);
        chk("R11 fault sticky", int'(fault), 1);
    endtask

    initial begin
        t_reset_and_sync();
        t_ch1_first();
        t_ch2_then_ch1_early();
        t_ch1_after_ch2_ramp_and_uv();
        t_overheat();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500us;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule